// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block watches the access activity of both ports of a shared two-port memory and keeps one message-pending flag per port. The two topmost word addresses act as mailboxes: the all-ones address belongs to port B and the address one below it belongs to port A. When a port writes into the opposite port's mailbox, the flag toward the mailbox owner is raised. The flag drops when the owner reads its own mailbox. Neither the memory array nor the message data is modelled here. The block tracks only the flags.

Every input is sampled on the rising clock edge, and each flag output changes in the cycle that follows. A port's arbitration busy input blocks both its raise action and its clear action. Accesses made with the semaphore select active never touch the flags, and neither do accesses made with the port enable inactive. The reset input asserts asynchronously and is released synchronously through a two-stage synchroniser.

Top module: `dp_mbx_irq`

## Requirements
- R1: While rst_n is low, and after its release, both pa_irq_n and pb_irq_n read 1 (no message pending). Asserting rst_n low clears pending flags immediately.
- R2: A port A write (pa_en=1, pa_sem=0, pa_wr=1, pa_busy=0) to address all-ones drives pb_irq_n to 0 after the next rising edge.
- R3: A port B write to address all-ones minus one drives pa_irq_n to 0 after the next rising edge.
- R4: A read by the owner of its own mailbox (en=1, sem=0, rd=1, wr=0, busy=0) returns that port's irq_n to 1 after the next rising edge. Port A's mailbox is all-ones minus one and port B's mailbox is all-ones.
- R5: A read by a port of the other port's mailbox leaves the other port's flag unchanged.
- R6: While a port's busy input is 1, its write to the opposite mailbox does not raise the opposite flag.
- R7: While a port's busy input is 1, its read of its own mailbox does not clear its flag.
- R8: If a raise and a clear of the same flag fall in the same cycle, the flag ends up pending (irq_n=0).
- R9: An access with en=0, or with sem=1, changes neither flag.
- R10: Writes to other addresses, a port writing its own mailbox, and reads of any other address leave both flags unchanged. A cycle with wr=1 is a write even when rd=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pa_en | input | 1 | Port A memory enable, active high |
| pa_sem | input | 1 | Port A semaphore select, active high |
| pa_wr | input | 1 | Port A write strobe |
| pa_rd | input | 1 | Port A read/output-enable strobe |
| pa_busy | input | 1 | Port A arbitration busy, active high |
| pa_addr | input | ADDR_W | Port A word address |
| pb_en | input | 1 | Port B memory enable, active high |
| pb_sem | input | 1 | Port B semaphore select, active high |
| pb_wr | input | 1 | Port B write strobe |
| pb_rd | input | 1 | Port B read/output-enable strobe |
| pb_busy | input | 1 | Port B arbitration busy, active high |
| pb_addr | input | ADDR_W | Port B word address |
| pa_irq_n | output | 1 | Message pending for port A, active low |
| pb_irq_n | output | 1 | Message pending for port B, active low |

## Verification
The bench drives a raise and a clear of the same flag in one cycle. A design that gave the clear priority would lose the message and show irq_n at 1. It also reads each mailbox from the wrong port, where a decoder that ignored the port identity would wrongly drop the flag. Busy and semaphore accesses are aimed at exactly the mailbox addresses, so a missing gate shows up as a flag that moves. A port writing its own mailbox, and a write with the read strobe also high, catch a decoder that swapped the owner and peer addresses or that treated the strobes loosely.

// File: rtl/dp_mbx_pkg.sv
package dp_mbx_pkg;
  localparam int NPORTS = 2;
  localparam int PORT_A = 0;
  localparam int PORT_B = 1;

  typedef struct packed {
    logic en;
    logic sem;
    logic wr;
    logic rd;
    logic busy;
  } mbx_ctl_t;
endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import dp_mbx_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter logic [ADDR_W-1:0] OWN_BOX  = '1,
  parameter logic [ADDR_W-1:0] PEER_BOX = '1
) (
  input  mbx_ctl_t          ctl,
  input  logic [ADDR_W-1:0] addr,
  output logic              raise_peer,
  output logic              drop_own
);
  logic mem_ok;
  logic is_wr;
  logic is_rd;

  always_comb begin
    mem_ok     = ctl.en && !ctl.sem && !ctl.busy;
    is_wr      = ctl.wr;
    is_rd      = ctl.rd && !ctl.wr;
    raise_peer = mem_ok && is_wr && (addr == PEER_BOX);
    drop_own   = mem_ok && is_rd && (addr == OWN_BOX);
  end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic srst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_n_o
);
  logic pend_q;
  logic pend_d;
  logic upd_en;

  always_comb begin
    upd_en = set_i || clr_i;
    pend_d = set_i ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     pend_q <= 1'b0;
    else if (upd_en) pend_q <= pend_d;
  end

  assign irq_n_o = !pend_q;

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!srst_n)
    set_i |=> !irq_n_o);
  p_clear_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (clr_i && !set_i) |=> irq_n_o);
  p_hold_r10: assert property (@(posedge clk) disable iff (!srst_n)
    (!set_i && !clr_i) |=> $stable(irq_n_o));
endmodule

// File: rtl/dp_mbx_irq.sv
module dp_mbx_irq
  import dp_mbx_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pa_en,
  input  logic              pa_sem,
  input  logic              pa_wr,
  input  logic              pa_rd,
  input  logic              pa_busy,
  input  logic [ADDR_W-1:0] pa_addr,
  input  logic              pb_en,
  input  logic              pb_sem,
  input  logic              pb_wr,
  input  logic              pb_rd,
  input  logic              pb_busy,
  input  logic [ADDR_W-1:0] pb_addr,
  output logic              pa_irq_n,
  output logic              pb_irq_n
);
  localparam logic [ADDR_W-1:0] BOX_B = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] BOX_A = BOX_B - 1'b1;

  logic                    srst_n;
  mbx_ctl_t                ctl   [NPORTS];
  logic [ADDR_W-1:0]       addr  [NPORTS];
  logic [NPORTS-1:0]       raise;
  logic [NPORTS-1:0]       drop;
  logic [NPORTS-1:0]       irq_n;

  always_comb begin
    ctl[PORT_A]  = '{en: pa_en, sem: pa_sem, wr: pa_wr, rd: pa_rd, busy: pa_busy};
    ctl[PORT_B]  = '{en: pb_en, sem: pb_sem, wr: pb_wr, rd: pb_rd, busy: pb_busy};
    addr[PORT_A] = pa_addr;
    addr[PORT_B] = pb_addr;
  end

  mbx_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    localparam logic [ADDR_W-1:0] OWN  = (i == PORT_A) ? BOX_A : BOX_B;
    localparam logic [ADDR_W-1:0] PEER = (i == PORT_A) ? BOX_B : BOX_A;

    mbx_port_decode #(
      .ADDR_W   (ADDR_W),
      .OWN_BOX  (OWN),
      .PEER_BOX (PEER)
    ) u_dec (
      .ctl        (ctl[i]),
      .addr       (addr[i]),
      .raise_peer (raise[i]),
      .drop_own   (drop[i])
    );

    mbx_flag u_flag (
      .clk     (clk),
      .srst_n  (srst_n),
      .set_i   (raise[NPORTS-1-i]),
      .clr_i   (drop[i]),
      .irq_n_o (irq_n[i])
    );

    p_busy_gate_r6_r7: assert property (@(posedge clk) disable iff (!srst_n)
      ctl[i].busy |-> (!raise[i] && !drop[i]));
    p_sel_gate_r9: assert property (@(posedge clk) disable iff (!srst_n)
      (ctl[i].sem || !ctl[i].en) |-> (!raise[i] && !drop[i]));
    p_read_no_raise_r5: assert property (@(posedge clk) disable iff (!srst_n)
      !ctl[i].wr |-> !raise[i]);
  end

  assign pa_irq_n = irq_n[PORT_A];
  assign pb_irq_n = irq_n[PORT_B];

  p_reset_idle_r1: assert property (@(posedge clk)
    !srst_n |-> (pa_irq_n && pb_irq_n));
endmodule

// File: tb/dp_mbx_irq_test.sv
module dp_mbx_irq_test;
  localparam int ADDR_W = 14;
  localparam logic [ADDR_W-1:0] TOPA = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] BOXA = TOPA - 1'b1;

  logic clk = 1'b0;
  logic rst_n;
  logic pa_en, pa_sem, pa_wr, pa_rd, pa_busy;
  logic pb_en, pb_sem, pb_wr, pb_rd, pb_busy;
  logic [ADDR_W-1:0] pa_addr, pb_addr;
  logic pa_irq_n, pb_irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dp_mbx_irq #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .pa_en(pa_en), .pa_sem(pa_sem), .pa_wr(pa_wr), .pa_rd(pa_rd),
    .pa_busy(pa_busy), .pa_addr(pa_addr),
    .pb_en(pb_en), .pb_sem(pb_sem), .pb_wr(pb_wr), .pb_rd(pb_rd),
    .pb_busy(pb_busy), .pb_addr(pb_addr),
    .pa_irq_n(pa_irq_n), .pb_irq_n(pb_irq_n)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic idle();
    pa_en = 0; pa_sem = 0; pa_wr = 0; pa_rd = 0; pa_busy = 0; pa_addr = '0;
    pb_en = 0; pb_sem = 0; pb_wr = 0; pb_rd = 0; pb_busy = 0; pb_addr = '0;
  endtask

  task automatic a_acc(input logic en, input logic sem, input logic wr,
                       input logic rd, input logic busy, input logic [ADDR_W-1:0] ad);
    pa_en = en; pa_sem = sem; pa_wr = wr; pa_rd = rd; pa_busy = busy; pa_addr = ad;
  endtask

  task automatic b_acc(input logic en, input logic sem, input logic wr,
                       input logic rd, input logic busy, input logic [ADDR_W-1:0] ad);
    pb_en = en; pb_sem = sem; pb_wr = wr; pb_rd = rd; pb_busy = busy; pb_addr = ad;
  endtask

  // Stimulus set at a falling edge is held across one rising edge.
  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    idle();
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk("R1 pa in reset", pa_irq_n, 1'b1);
    chk("R1 pb in reset", pb_irq_n, 1'b1);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 pa after release", pa_irq_n, 1'b1);
    chk("R1 pb after release", pb_irq_n, 1'b1);
  endtask

  task automatic t_b_mailbox();
    a_acc(1, 0, 1, 0, 0, TOPA); tick();
    chk("R2 pb raised", pb_irq_n, 1'b0);
    chk("R10 pa untouched", pa_irq_n, 1'b1);
    a_acc(1, 0, 0, 1, 0, TOPA); tick();
    chk("R5 peer read keeps pb", pb_irq_n, 1'b0);
    b_acc(1, 0, 0, 1, 1, TOPA); tick();
    chk("R7 busy read keeps pb", pb_irq_n, 1'b0);
    b_acc(1, 1, 0, 1, 0, TOPA); tick();
    chk("R9 sem read keeps pb", pb_irq_n, 1'b0);
    b_acc(0, 0, 0, 1, 0, TOPA); tick();
    chk("R9 disabled read keeps pb", pb_irq_n, 1'b0);
    b_acc(1, 0, 0, 1, 0, BOXA); tick();
    chk("R5 pb reading pa box keeps pb", pb_irq_n, 1'b0);
    b_acc(1, 0, 0, 1, 0, TOPA); tick();
    chk("R4 pb cleared", pb_irq_n, 1'b1);
  endtask

  task automatic t_a_mailbox();
    b_acc(1, 0, 1, 0, 0, BOXA); tick();
    chk("R3 pa raised", pa_irq_n, 1'b0);
    chk("R10 pb untouched", pb_irq_n, 1'b1);
    a_acc(1, 0, 0, 1, 1, BOXA); tick();
    chk("R7 busy read keeps pa", pa_irq_n, 1'b0);
    a_acc(1, 0, 1, 1, 0, BOXA); tick();
    chk("R10 write with rd high is not a read", pa_irq_n, 1'b0);
    a_acc(1, 0, 0, 1, 0, BOXA); tick();
    chk("R4 pa cleared", pa_irq_n, 1'b1);
  endtask

  task automatic t_blocked();
    a_acc(1, 0, 1, 0, 1, TOPA); tick();
    chk("R6 busy write no raise pb", pb_irq_n, 1'b1);
    b_acc(1, 0, 1, 0, 1, BOXA); tick();
    chk("R6 busy write no raise pa", pa_irq_n, 1'b1);
    a_acc(0, 0, 1, 0, 0, TOPA); tick();
    chk("R9 disabled write no raise", pb_irq_n, 1'b1);
    a_acc(1, 1, 1, 0, 0, TOPA); tick();
    chk("R9 sem write no raise", pb_irq_n, 1'b1);
  endtask

  task automatic t_other_addr();
    a_acc(1, 0, 1, 0, 0, BOXA); tick();
    chk("R10 pa own box write pa", pa_irq_n, 1'b1);
    chk("R10 pa own box write pb", pb_irq_n, 1'b1);
    b_acc(1, 0, 1, 0, 0, TOPA); tick();
    chk("R10 pb own box write", pb_irq_n, 1'b1);
    a_acc(1, 0, 1, 0, 0, 14'h1234); b_acc(1, 0, 1, 0, 0, 14'h3FFD); tick();
    chk("R10 plain write pa", pa_irq_n, 1'b1);
    chk("R10 plain write pb", pb_irq_n, 1'b1);
  endtask

  task automatic t_priority();
    b_acc(1, 0, 1, 0, 0, BOXA); a_acc(1, 0, 0, 1, 0, BOXA); tick();
    chk("R8 raise beats clear from idle", pa_irq_n, 1'b0);
    b_acc(1, 0, 1, 0, 0, BOXA); a_acc(1, 0, 0, 1, 0, BOXA); tick();
    chk("R8 raise beats clear while pending", pa_irq_n, 1'b0);
    a_acc(1, 0, 1, 0, 0, TOPA); b_acc(1, 0, 0, 1, 0, TOPA); tick();
    chk("R8 pb raise beats clear", pb_irq_n, 1'b0);
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    rst_n = 0;
    #1;
    chk("R1 async clear pa", pa_irq_n, 1'b1);
    chk("R1 async clear pb", pb_irq_n, 1'b1);
    @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_b_mailbox();
    t_a_mailbox();
    t_blocked();
    t_other_addr();
    t_priority();
    t_reset_mid();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule